// File: doc/BRIEF.md
# Receive Message Object Allocator

This block places each accepted received CAN frame into one object of a bank of message objects. The search runs upward from object 0. It takes the first object that meets all of these conditions: the object is valid, it is set for receive, it holds no unread frame, and its filter matches the frame. The search stops at the first valid receive object that is flagged as the chain end. Objects above that one are never searched. If every matching object in the chain is full and the chain-end object itself matches, the frame overwrites the chain-end object and that object records that a frame was lost. In any other case the frame is dropped.

Software-side logic sets up each object's filter through a configuration write port. It clears an object after reading it through an acknowledge port, and reads the stored contents through a combinational readout port. A vector with one bit per object shows which objects hold unread frames. Bit-level reception and checking of the frame are handled upstream. The transfer engine on the processor side is handled downstream.

Top module: `rxa_alloc`

## Requirements
- R1: After reset every object is invalid, `newdat_vec` is zero and `wr_done` is low, so a frame offered before any configuration is not stored.
- R2: A frame with `frm_valid` high is stored in the lowest-numbered searched object that is free and matching. One clock edge later, `wr_done` pulses for one cycle with `wr_idx` set to that object and `wr_lost` set to 0.
- R3: A stored object sets its bit in `newdat_vec` (bit k is object k) and its interrupt-pending flag. Through `rd_sel` it returns the received identifier, length code and data.
- R4: With use-mask set, only identifier bits where the filter mask is 1 must equal the filter identifier, so a zero mask accepts every identifier. With use-mask clear, all 29 identifier bits must be equal.
- R5: The frame's extended-format flag must equal the object's extended flag, whatever the mask.
- R6: Objects above the first valid receive object with its chain-end flag set are never written.
- R7: When no searched object is free and the chain-end object matches, that object is overwritten, its message-lost flag is set and `wr_lost` is 1.
- R8: A frame with no free matching object and no matching chain-end object is dropped: no `wr_done` and no change to `newdat_vec`.
- R9: An acknowledge of an object clears its new-data, interrupt-pending and message-lost flags, so the object can be filled again.
- R10: Objects set to transmit direction, or not valid, never receive a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Accepted frame offered this cycle |
| frm_ext | input | 1 | Frame uses 29-bit identifier |
| frm_id | input | 29 | Frame identifier (standard identifiers in bits 10:0) |
| frm_dlc | input | 4 | Frame length code |
| frm_data | input | 64 | Frame payload |
| cfg_wr | input | 1 | Write filter of object `cfg_sel` and clear its flags |
| cfg_sel | input | 4 | Object being configured |
| cfg_valid | input | 1 | Object valid |
| cfg_xmit | input | 1 | Object is transmit direction |
| cfg_ext | input | 1 | Object expects extended frames |
| cfg_umask | input | 1 | Use the filter mask |
| cfg_eob | input | 1 | Object ends the receive chain |
| cfg_id | input | 29 | Filter identifier |
| cfg_mask | input | 29 | Filter mask, 1 means compare |
| ack_wr | input | 1 | Clear flags of object `ack_sel` |
| ack_sel | input | 4 | Object being acknowledged |
| rd_sel | input | 4 | Object to read out |
| rd_id | output | 29 | Received identifier of selected object |
| rd_dlc | output | 4 | Received length code of selected object |
| rd_data | output | 64 | Received payload of selected object |
| rd_intpnd | output | 1 | Interrupt-pending flag of selected object |
| rd_msglst | output | 1 | Message-lost flag of selected object |
| newdat_vec | output | 16 | Unread-frame flag per object |
| wr_done | output | 1 | A frame was stored at the last edge |
| wr_idx | output | 4 | Object that received the frame |
| wr_lost | output | 1 | The store overwrote an unread frame |

## Verification
Each frame is sampled at one rising edge. The store result (`wr_done`, `wr_idx`, `wr_lost`) and the updated `newdat_vec` are registered at that same edge, so they are due exactly one edge after the frame is presented. An acknowledge or configuration write takes effect at its edge in the same way. The bench drives every input on a falling edge, holds it across one rising edge, and samples the results at the next falling edge. That is the only window in which the one-cycle `wr_done` pulse is visible. The readout port is combinational, so it is checked shortly after `rd_sel` changes, with no edge in between.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  localparam int ID_W = 29;

  typedef struct packed {
    logic            valid;
    logic            xmit;
    logic            ext;
    logic            umask;
    logic            eob;
    logic [ID_W-1:0] id;
    logic [ID_W-1:0] mask;
  } rx_filt_t;
endpackage

// File: rtl/rxa_match.sv
module rxa_match
  import rxa_pkg::*;
#(
  parameter int N_OBJ = 16
) (
  input  rx_filt_t [N_OBJ-1:0] filt,
  input  logic                 frm_ext,
  input  logic [ID_W-1:0]      frm_id,
  output logic [N_OBJ-1:0]     cand_vec,
  output logic [N_OBJ-1:0]     rxv_vec,
  output logic [N_OBJ-1:0]     eob_vec
);
  for (genvar g = 0; g < N_OBJ; g++) begin : g_obj
    logic [ID_W-1:0] eff_mask;
    logic            id_eq;
    assign eff_mask    = filt[g].umask ? filt[g].mask : {ID_W{1'b1}};
    assign id_eq       = ((frm_id ^ filt[g].id) & eff_mask) == '0;
    assign rxv_vec[g]  = filt[g].valid & ~filt[g].xmit;
    assign eob_vec[g]  = filt[g].eob;
    assign cand_vec[g] = rxv_vec[g] & id_eq & (frm_ext == filt[g].ext);
  end
endmodule

// File: rtl/rxa_pick.sv
module rxa_pick #(
  parameter int N_OBJ = 16,
  localparam int IDX_W = $clog2(N_OBJ)
) (
  input  logic [N_OBJ-1:0] cand_vec,
  input  logic [N_OBJ-1:0] rxv_vec,
  input  logic [N_OBJ-1:0] eob_vec,
  input  logic [N_OBJ-1:0] full_vec,
  output logic             go,
  output logic             ovw,
  output logic [IDX_W-1:0] sel
);
  logic             stop, found, tail_found, tail_match;
  logic [IDX_W-1:0] sel_free, sel_tail;

  always_comb begin
    stop       = 1'b0;
    found      = 1'b0;
    tail_found = 1'b0;
    tail_match = 1'b0;
    sel_free   = '0;
    sel_tail   = '0;
    for (int i = 0; i < N_OBJ; i++) begin
      if (!stop) begin
        if (cand_vec[i] && !full_vec[i] && !found) begin
          found    = 1'b1;
          sel_free = IDX_W'(i);
        end
        if (rxv_vec[i] && eob_vec[i]) begin
          stop       = 1'b1;
          tail_found = 1'b1;
          tail_match = cand_vec[i];
          sel_tail   = IDX_W'(i);
        end
      end
    end
    ovw = !found && tail_found && tail_match;
    go  = found || ovw;
    sel = found ? sel_free : sel_tail;
  end
endmodule

// File: rtl/rxa_objs.sv
module rxa_objs
  import rxa_pkg::*;
#(
  parameter int N_OBJ  = 16,
  parameter int DATA_W = 64,
  parameter int DLC_W  = 4,
  localparam int IDX_W = $clog2(N_OBJ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [IDX_W-1:0]     cfg_sel,
  input  rx_filt_t             cfg_filt,
  input  logic                 ack_wr,
  input  logic [IDX_W-1:0]     ack_sel,
  input  logic                 st_en,
  input  logic [IDX_W-1:0]     st_sel,
  input  logic [ID_W-1:0]      st_id,
  input  logic [DLC_W-1:0]     st_dlc,
  input  logic [DATA_W-1:0]    st_data,
  input  logic [IDX_W-1:0]     rd_sel,
  output rx_filt_t [N_OBJ-1:0] filt,
  output logic [N_OBJ-1:0]     newdat,
  output logic [ID_W-1:0]      rd_id,
  output logic [DLC_W-1:0]     rd_dlc,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_intpnd,
  output logic                 rd_msglst
);
  logic [ID_W-1:0]   rid_a  [N_OBJ];
  logic [DLC_W-1:0]  rdlc_a [N_OBJ];
  logic [DATA_W-1:0] rdat_a [N_OBJ];
  logic [N_OBJ-1:0]  intpnd, msglst;

  for (genvar g = 0; g < N_OBJ; g++) begin : g_obj
    logic              cfg_hit, st_hit, ack_hit;
    logic              nd_q, ip_q, ml_q, nd_n, ip_n, ml_n;
    rx_filt_t          f_q;
    logic [ID_W-1:0]   id_q;
    logic [DLC_W-1:0]  dlc_q;
    logic [DATA_W-1:0] dat_q;

    assign cfg_hit = cfg_wr && (cfg_sel == IDX_W'(g));
    assign st_hit  = st_en  && (st_sel  == IDX_W'(g));
    assign ack_hit = ack_wr && (ack_sel == IDX_W'(g));

    always_comb begin
      nd_n = nd_q;
      ip_n = ip_q;
      ml_n = ml_q;
      if (cfg_hit) begin
        nd_n = 1'b0;
        ip_n = 1'b0;
        ml_n = 1'b0;
      end else if (st_hit) begin
        nd_n = 1'b1;
        ip_n = 1'b1;
        ml_n = ml_q | nd_q;
      end else if (ack_hit) begin
        nd_n = 1'b0;
        ip_n = 1'b0;
        ml_n = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q  <= '0;
        nd_q <= 1'b0;
        ip_q <= 1'b0;
        ml_q <= 1'b0;
      end else begin
        if (cfg_hit) f_q <= cfg_filt;
        nd_q <= nd_n;
        ip_q <= ip_n;
        ml_q <= ml_n;
      end
    end

    always_ff @(posedge clk) begin
      if (st_hit) begin
        id_q  <= st_id;
        dlc_q <= st_dlc;
        dat_q <= st_data;
      end
    end

    assign filt[g]   = f_q;
    assign newdat[g] = nd_q;
    assign intpnd[g] = ip_q;
    assign msglst[g] = ml_q;
    assign rid_a[g]  = id_q;
    assign rdlc_a[g] = dlc_q;
    assign rdat_a[g] = dat_q;
  end

  assign rd_id     = rid_a[rd_sel];
  assign rd_dlc    = rdlc_a[rd_sel];
  assign rd_data   = rdat_a[rd_sel];
  assign rd_intpnd = intpnd[rd_sel];
  assign rd_msglst = msglst[rd_sel];
endmodule

// File: rtl/rxa_alloc.sv
module rxa_alloc
  import rxa_pkg::*;
#(
  parameter int N_OBJ  = 16,
  parameter int DATA_W = 64,
  parameter int DLC_W  = 4,
  localparam int IDX_W = $clog2(N_OBJ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic              frm_ext,
  input  logic [ID_W-1:0]   frm_id,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic              cfg_valid,
  input  logic              cfg_xmit,
  input  logic              cfg_ext,
  input  logic              cfg_umask,
  input  logic              cfg_eob,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [ID_W-1:0]   cfg_mask,
  input  logic              ack_wr,
  input  logic [IDX_W-1:0]  ack_sel,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [ID_W-1:0]   rd_id,
  output logic [DLC_W-1:0]  rd_dlc,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_intpnd,
  output logic              rd_msglst,
  output logic [N_OBJ-1:0]  newdat_vec,
  output logic              wr_done,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              wr_lost
);
  logic [1:0]           rst_sync;
  logic                 srst_n;
  rx_filt_t             cfg_filt;
  rx_filt_t [N_OBJ-1:0] filt;
  logic [N_OBJ-1:0]     cand_vec, rxv_vec, eob_vec;
  logic                 go, ovw, st_en;
  logic [IDX_W-1:0]     sel;
  logic                 done_n, lost_n;
  logic [IDX_W-1:0]     idx_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  assign cfg_filt = '{valid: cfg_valid, xmit: cfg_xmit, ext: cfg_ext,
                      umask: cfg_umask, eob: cfg_eob, id: cfg_id, mask: cfg_mask};

  rxa_match #(.N_OBJ(N_OBJ)) u_match (
    .filt(filt), .frm_ext(frm_ext), .frm_id(frm_id),
    .cand_vec(cand_vec), .rxv_vec(rxv_vec), .eob_vec(eob_vec)
  );

  rxa_pick #(.N_OBJ(N_OBJ)) u_pick (
    .cand_vec(cand_vec), .rxv_vec(rxv_vec), .eob_vec(eob_vec),
    .full_vec(newdat_vec), .go(go), .ovw(ovw), .sel(sel)
  );

  assign st_en = frm_valid && go && !(cfg_wr && (cfg_sel == sel));

  rxa_objs #(.N_OBJ(N_OBJ), .DATA_W(DATA_W), .DLC_W(DLC_W)) u_objs (
    .clk(clk), .rst_n(srst_n),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_filt(cfg_filt),
    .ack_wr(ack_wr), .ack_sel(ack_sel),
    .st_en(st_en), .st_sel(sel), .st_id(frm_id), .st_dlc(frm_dlc), .st_data(frm_data),
    .rd_sel(rd_sel), .filt(filt), .newdat(newdat_vec),
    .rd_id(rd_id), .rd_dlc(rd_dlc), .rd_data(rd_data),
    .rd_intpnd(rd_intpnd), .rd_msglst(rd_msglst)
  );

  always_comb begin
    done_n = st_en;
    idx_n  = st_en ? sel : wr_idx;
    lost_n = st_en && ovw;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wr_done <= 1'b0;
      wr_idx  <= '0;
      wr_lost <= 1'b0;
    end else begin
      wr_done <= done_n;
      wr_idx  <= idx_n;
      wr_lost <= lost_n;
    end
  end
endmodule

// File: rtl/rxa_alloc_chk.sv
module rxa_alloc_chk #(
  parameter int N_OBJ = 16,
  localparam int IDX_W = $clog2(N_OBJ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             ack_wr,
  input logic [IDX_W-1:0] ack_sel,
  input logic [N_OBJ-1:0] newdat_vec,
  input logic             wr_done,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_lost
);
  AST_DONE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $past(frm_valid)); // R2
  AST_STORE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (((newdat_vec >> wr_idx) & 1'b1) != '0)); // R3
  AST_NEWDAT_RISE_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ((newdat_vec & ~$past(newdat_vec)) != '0) |-> (wr_done && $countones(newdat_vec & ~$past(newdat_vec)) == 1)); // R8
  AST_LOST_MEANS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && wr_lost) |-> ((($past(newdat_vec) >> wr_idx) & 1'b1) != '0)); // R7
  AST_FREE_STORE_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !wr_lost) |-> ((($past(newdat_vec) >> wr_idx) & 1'b1) == '0)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_wr) && !(wr_done && wr_idx == $past(ack_sel)))
      |-> (((newdat_vec >> $past(ack_sel)) & 1'b1) == '0)); // R9
endmodule

bind rxa_alloc rxa_alloc_chk #(.N_OBJ(N_OBJ)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .ack_wr(ack_wr), .ack_sel(ack_sel),
  .newdat_vec(newdat_vec), .wr_done(wr_done), .wr_idx(wr_idx), .wr_lost(wr_lost)
);

// File: tb/rxa_alloc_bench.sv
module rxa_alloc_bench;
  localparam int CLK_PER = 10;
  localparam int NV = 8;
  // entry: {ext, id[28:0], exp_done, exp_idx[3:0], exp_lost}
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 29'h125,      1'b1, 4'd2, 1'b0},
    {1'b0, 29'h12A,      1'b1, 4'd5, 1'b0},
    {1'b1, 29'h0ABCDE77, 1'b1, 4'd3, 1'b0},
    {1'b0, 29'h055,      1'b1, 4'd4, 1'b0},
    {1'b0, 29'h056,      1'b1, 4'd5, 1'b1},
    {1'b1, 29'h0ABCDF00, 1'b0, 4'd0, 1'b0},
    {1'b0, 29'h7FF,      1'b1, 4'd5, 1'b1},
    {1'b1, 29'h0ABCDE01, 1'b0, 4'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n, frm_valid, frm_ext;
  logic [28:0] frm_id;
  logic [3:0]  frm_dlc;
  logic [63:0] frm_data;
  logic        cfg_wr, cfg_valid, cfg_xmit, cfg_ext, cfg_umask, cfg_eob;
  logic [3:0]  cfg_sel, ack_sel, rd_sel, wr_idx, rd_dlc;
  logic [28:0] cfg_id, cfg_mask, rd_id;
  logic        ack_wr, rd_intpnd, rd_msglst, wr_done, wr_lost;
  logic [63:0] rd_data;
  logic [15:0] newdat_vec;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  rxa_alloc u_rxa_alloc (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic ext, input logic [28:0] id, input logic [3:0] dlc,
                      input logic [63:0] data);
    @(negedge clk);
    frm_valid = 1'b1; frm_ext = ext; frm_id = id; frm_dlc = dlc; frm_data = data;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic cfg(input logic [3:0] sel, input logic v, input logic x, input logic e,
                     input logic um, input logic eob, input logic [28:0] id,
                     input logic [28:0] mask);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_valid = v; cfg_xmit = x; cfg_ext = e;
    cfg_umask = um; cfg_eob = eob; cfg_id = id; cfg_mask = mask;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ack(input logic [3:0] sel);
    @(negedge clk);
    ack_wr = 1'b1; ack_sel = sel;
    @(negedge clk);
    ack_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frm_valid = 1'b0; frm_ext = 1'b0; frm_id = '0; frm_dlc = '0; frm_data = '0;
    cfg_wr = 1'b0; cfg_sel = '0; cfg_valid = 1'b0; cfg_xmit = 1'b0; cfg_ext = 1'b0;
    cfg_umask = 1'b0; cfg_eob = 1'b0; cfg_id = '0; cfg_mask = '0;
    ack_wr = 1'b0; ack_sel = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    chk("R1 newdat at reset", 64'(newdat_vec), 64'h0);
    chk("R1 wr_done at reset", 64'(wr_done), 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send(1'b0, 29'h100, 4'd1, 64'h0);
    chk("R1 no store before config", 64'(wr_done), 64'h0);

    cfg(4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 29'h0, 29'h0);             // transmit
    cfg(4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 29'h0, 29'h0);             // invalid
    cfg(4'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 29'h120, 29'h7F0);
    cfg(4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 29'h0ABCDE00, 29'h1FFFFF00);
    cfg(4'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 29'h055, 29'h0);           // exact
    cfg(4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 29'h0, 29'h0);             // chain end
    cfg(4'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 29'h0, 29'h0);             // beyond chain

    // R2 R4 R5 R7 R8 R10 via table
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][35], VEC[i][34:6], 4'd8, {35'h0, VEC[i][34:6]});
      chk($sformatf("R2 vec%0d done", i), 64'(wr_done), 64'(VEC[i][5]));
      if (VEC[i][5]) begin
        chk($sformatf("R2 vec%0d idx", i), 64'(wr_idx), 64'(VEC[i][4:1]));
        chk($sformatf("R7 vec%0d lost", i), 64'(wr_lost), 64'(VEC[i][0]));
      end
    end
    chk("R10 R8 newdat after table", 64'(newdat_vec), 64'h3C);

    rd_sel = 4'd5; #1;
    chk("R7 msglst on chain end", 64'(rd_msglst), 64'h1);
    chk("R7 overwritten id", 64'(rd_id), 64'h7FF);

    ack(4'd4);
    send(1'b0, 29'h056, 4'd2, 64'h0);
    chk("R4 exact compare skips obj4", 64'(wr_idx), 64'd5);
    chk("R4 overwrite lost", 64'(wr_lost), 64'h1);
    chk("R4 newdat", 64'(newdat_vec), 64'h2C);

    ack(4'd5);
    chk("R9 newdat after ack", 64'(newdat_vec), 64'h0C);
    rd_sel = 4'd5; #1;
    chk("R9 msglst cleared", 64'(rd_msglst), 64'h0);
    chk("R9 intpnd cleared", 64'(rd_intpnd), 64'h0);

    send(1'b0, 29'h300, 4'd5, 64'h1122334455667788);
    chk("R9 refill done", 64'(wr_done), 64'h1);
    chk("R9 refill not lost", 64'(wr_lost), 64'h0);
    rd_sel = 4'd5; #1;
    chk("R3 rd_id", 64'(rd_id), 64'h300);
    chk("R3 rd_dlc", 64'(rd_dlc), 64'd5);
    chk("R3 rd_data", rd_data, 64'h1122334455667788);
    chk("R3 intpnd", 64'(rd_intpnd), 64'h1);
    chk("R3 newdat bit5", 64'(newdat_vec), 64'h2C);

    ack(4'd2);
    send(1'b0, 29'h121, 4'd1, 64'h0);
    chk("R2 lowest free chosen", 64'(wr_idx), 64'd2);

    ack(4'd2);
    send(1'b1, 29'h125, 4'd1, 64'h0);
    chk("R5 ext mismatch dropped", 64'(wr_done), 64'h0);
    chk("R5 newdat unchanged", 64'(newdat_vec), 64'h28);

    send(1'b0, 29'h400, 4'd1, 64'h0);
    chk("R6 chain end overwritten", 64'(wr_idx), 64'd5);
    chk("R6 object 6 untouched", 64'(newdat_vec[6]), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule